// File: doc/BRIEF.md
# Ping-Pong Decoupled Access Buffer

This block decouples a producer of data words from a compute stage that consumes them. It holds two equal banks of `DEPTH` words each. Accepted words fill one bank. In the same beats, the bank filled in the previous period is drained toward the compute stage, one word per accepted beat. The write-side selection flips after every `DEPTH` accepted words, which is one period. A read-side selection flips one period later, so every word reaches the compute stage exactly one period after it was stored.

Each write goes to the active bank at the current slot. In the same cycle the idle bank receives zero at that slot, after its old word has been read out. The downstream word is therefore the sum of both bank outputs at the shared slot, and no bank multiplexer is needed. Once the first period has been filled, the compute stage gets one word for every accepted input word and never stalls.

Top module: `pp_access_buffer`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is applied and on the first cycle after it, `out_valid` is 0, `out_data` is 0 and `out_bank` is 0.
- R2: The first `DEPTH` accepted words after reset produce no `out_valid`. They only fill bank 0.
- R3: From the word with index `DEPTH` onward (0-based count of accepted words since reset), each accepted word raises `out_valid` in the next cycle. `out_data` then carries the word accepted exactly `DEPTH` accepted beats earlier, unchanged.
- R4: A cycle with `in_valid` low advances nothing. In the next cycle `out_valid` is 0 and `out_data` keeps its previous value. The word alignment of R3 counts accepted beats only.
- R5: `out_bank` gives the bank the delivered word was read from: 0 for words written in even periods (counting from 0), 1 for words written in odd periods.
- R6: Words equal to all-zeros and all-ones pass through bit-exact. The zero-filled idle bank never changes a delivered value.
- R7: A reset in the middle of a stream discards all stored words. The next `DEPTH` accepted words again produce no output, and the next word after them is the first word accepted after that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Output word valid toward the compute stage |
| out_data | output | DATA_W | Word delivered to the compute stage |
| out_bank | output | 1 | Bank the delivered word came from |

## Verification
Suppose a slot of the idle bank is not zeroed, or the two selection bits lose their one-period offset. Then the first delivered word that touches that slot comes out as the sum of two stored words, or as a stale word. This shows on `out_data` one period after the fault at the latest. A fault in the slot counter or the period boundary shifts the word alignment, moves the first `out_valid`, or changes the `out_bank` pattern within one period. The bench compares every output cycle against a history of accepted words, so such faults are caught at the first affected output beat.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int NUM_BANKS = 2;

    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } bank_e;

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK_0) ? BANK_1 : BANK_0;
    endfunction

endpackage

// File: rtl/pp_sel_ctrl.sv
module pp_sel_ctrl
    import pp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] slot,
    output bank_e            wr_sel,
    output bank_e            rd_sel,
    output logic             primed
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);

    logic wrap;
    assign wrap = step && (slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= '0;
            wr_sel <= BANK_0;
            rd_sel <= BANK_0;
            primed <= 1'b0;
        end else if (step) begin
            if (wrap) begin
                slot   <= '0;
                wr_sel <= other_bank(wr_sel);
                rd_sel <= wr_sel;
                primed <= 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pp_bank.sv
module pp_bank #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[slot] <= wdata;
        end
    end

    assign rdata = mem[slot];

endmodule

// File: rtl/pp_merge.sv
module pp_merge
    import pp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              primed,
    input  bank_e             rd_sel,
    input  logic [DATA_W-1:0] rdata_0,
    input  logic [DATA_W-1:0] rdata_1,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_bank
);

    logic [DATA_W-1:0] sum;
    assign sum = rdata_0 + rdata_1;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_bank  <= 1'b0;
        end else begin
            out_valid <= step && primed;
            if (step && primed) begin
                out_data <= sum;
                out_bank <= rd_sel;
            end
        end
    end

endmodule

// File: rtl/pp_access_buffer.sv
module pp_access_buffer
    import pp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_bank
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]  slot;
    bank_e             wr_sel;
    bank_e             rd_sel;
    logic              primed;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    pp_sel_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .step   (in_valid),
        .slot   (slot),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel),
        .primed (primed)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [DATA_W-1:0] wdata;
        // active bank takes the input word, the idle bank is cleared at the slot
        assign wdata = (wr_sel == bank_e'(g)) ? in_data : '0;

        pp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (in_valid),
            .slot  (slot),
            .wdata (wdata),
            .rdata (bank_rd[g])
        );
    end

    pp_merge #(.DATA_W(DATA_W)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .step      (in_valid),
        .primed    (primed),
        .rd_sel    (rd_sel),
        .rdata_0   (bank_rd[0]),
        .rdata_1   (bank_rd[1]),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_bank  (out_bank)
    );

endmodule

// File: rtl/pp_access_buffer_chk.sv
module pp_access_buffer_chk
    import pp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input bank_e             wr_sel,
    input bank_e             rd_sel,
    input logic              primed,
    input logic [DATA_W-1:0] rd_0,
    input logic [DATA_W-1:0] rd_1
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] beats;
    always_ff @(posedge clk) begin
        if (rst) beats <= '0;
        else if (in_valid && beats != FULL) beats <= beats + 1'b1;
    end

    // R2: no output before a full period has been stored
    p_no_early_out_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(beats) == FULL);

    // R4: idle input cycles deliver nothing and leave the data alone
    p_idle_no_valid_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    // R5: once primed, the read bank is always the one not being written
    p_sel_lag_r5: assert property (@(posedge clk) disable iff (rst)
        primed |-> rd_sel != wr_sel);

    // R6: the bank not being read holds zero at the current slot
    p_idle_bank_zero_r6: assert property (@(posedge clk) disable iff (rst)
        ((rd_sel == BANK_0) ? rd_1 : rd_0) == '0);

endmodule

bind pp_access_buffer pp_access_buffer_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel),
    .primed    (primed),
    .rd_0      (bank_rd[0]),
    .rd_1      (bank_rd[1])
);

// File: tb/pp_access_buffer_tb.sv
`timescale 1ns/1ps
module pp_access_buffer_tb;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_bank;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DATA_W-1:0] hist [$];
    logic [DATA_W-1:0] last_out = '0;

    always #2 clk = ~clk;

    pp_access_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_bank  (out_bank)
    );

    function automatic bit exp_bank(input int n);
        return bit'(((n - DEPTH) / DEPTH) % 2);
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", out_valid, 0);
        check("R1", "out_data in reset", out_data, 0);
        check("R1", "out_bank in reset", out_bank, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_valid after reset", out_valid, 0);
        check("R1", "out_data after reset", out_data, 0);
        hist.delete();
        last_out = '0;
    endtask

    task automatic beat(input bit v, input logic [DATA_W-1:0] d, input string req);
        int n;
        in_valid = v;
        in_data  = d;
        n = hist.size();
        @(posedge clk);
        #1;
        if (v) begin
            hist.push_back(d);
            if (n < DEPTH) begin
                check("R2", "out_valid while filling", out_valid, 0);
            end else begin
                check(req, "out_valid", out_valid, 1);
                check(req, "out_data", out_data, hist[n - DEPTH]);
                check("R5", "out_bank", out_bank, exp_bank(n));
                last_out = hist[n - DEPTH];
            end
        end else begin
            check("R4", "out_valid on idle", out_valid, 0);
            check("R4", "out_data hold on idle", out_data, last_out);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R2: first period only fills
        for (int i = 0; i < DEPTH; i++) beat(1'b1, DATA_W'(16'h1000 + i), "R2");
        // R3: second period drains the first
        for (int i = 0; i < DEPTH; i++) beat(1'b1, DATA_W'(16'h2000 + i), "R3");

        // R6: extreme values through both banks
        for (int i = 0; i < 2 * DEPTH; i++) beat(1'b1, (i % 2) ? '1 : '0, "R6");
        for (int i = 0; i < 2 * DEPTH; i++) beat(1'b1, '1, "R6");

        // R4: idle gaps at and around period boundaries
        beat(1'b0, 16'hdead, "R4");
        for (int i = 0; i < DEPTH - 1; i++) beat(1'b1, DATA_W'($urandom), "R4");
        beat(1'b0, 16'hbeef, "R4");
        beat(1'b0, 16'hbeef, "R4");
        for (int i = 0; i < DEPTH + 3; i++) beat(1'b1, DATA_W'($urandom), "R4");

        // R3: random stream with random gaps
        for (int i = 0; i < 300; i++) begin
            beat(($urandom % 4) != 0, DATA_W'($urandom), "R3");
        end

        // R7: reset mid-stream, then refill
        for (int i = 0; i < 3; i++) beat(1'b1, DATA_W'($urandom), "R7");
        do_reset();
        for (int i = 0; i < DEPTH; i++) beat(1'b1, DATA_W'(16'h7000 + i), "R7");
        for (int i = 0; i < 3 * DEPTH; i++) beat(1'b1, DATA_W'($urandom), "R7");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule